// File: doc/BRIEF.md
# Serial Receive Holding Queue

This block sits between the line-side receiver of one serial channel and the host. The receiver hands it characters that are already framed, together with a break-event strobe. The block keeps up to three characters in a small circular store, which it tracks with a head index and a count of held characters. Each host read of the holding register returns the character at the head and removes it.

The block drives a ready status and a combined interrupt request. It marks line breaks, and each break places a zero character in the queue. The break interrupt is raised only when the host reads a character while the break mark is set. The receiver sees how many free slots remain and must not push beyond that number. If it pushes while the queue is full, the character is dropped and a sticky overrun flag is raised.

Host commands work as single-cycle strobes. They enable or disable receive, flush the queue, acknowledge the break interrupt and clear the error flags.

Top module: `rx_hold_queue`

## Requirements
- R1: The queue holds at most DEPTH (3) characters and returns them in the order they arrived, wrapping its slot index modulo DEPTH.
- R2: `rx_free` shows DEPTH minus the number held while receive is on, and 0 while receive is off. A push while receive is off is ignored.
- R3: The first character accepted into an empty queue sets `rx_ready` on the following cycle.
- R4: `host_data` always shows the head entry. A read while characters are held removes the head. The read that removes the last character clears `rx_ready` and leaves the head index where it is.
- R5: A read while the queue is empty returns the stale head entry and changes no state.
- R6: A pulse on `rx_break` sets `brk_flag` and enqueues one 0x00 character, provided receive is on and a slot is free. It takes priority over an `rx_valid` in the same cycle, and that character is dropped.
- R7: A read that removes a character while `brk_flag` is set clears `brk_flag` and sets `brk_irq`. `cmd_brk_ack` clears `brk_irq`, but a new raise in the same cycle wins.
- R8: `cmd_rx_flush` empties the queue, turns receive off and clears `rx_ready`. It takes priority over a push in the same cycle.
- R9: A push while DEPTH characters are held drops the character and sets the sticky `overrun` flag. `cmd_err_clr` clears `overrun` and `brk_flag`, but a new set in the same cycle wins.
- R10: `cmd_rx_on` turns receive on and `cmd_rx_off` turns it off. When both arrive in the same cycle, off wins. A push in that cycle is judged with the old enable.
- R11: `irq` is high exactly when `rx_ready` or `brk_irq` is high.
- R12: After reset the queue is empty, receive is off, and all flags, `irq` and `host_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receiver presents a framed character |
| rx_char | input | DATA_W | Character from the receiver |
| rx_break | input | 1 | Break detected on the line (one-cycle strobe) |
| rx_free | output | clog2(DEPTH+1) | Free slots available to the receiver |
| host_rd | input | 1 | Host reads the holding register |
| host_data | output | DATA_W | Head entry of the queue |
| cmd_rx_on | input | 1 | Enable receive |
| cmd_rx_off | input | 1 | Disable receive |
| cmd_rx_flush | input | 1 | Receive reset: empty queue, disable receive |
| cmd_brk_ack | input | 1 | Clear the break interrupt |
| cmd_err_clr | input | 1 | Clear overrun and break flags |
| rx_ready | output | 1 | At least one character is held |
| brk_flag | output | 1 | Break status |
| brk_irq | output | 1 | Break interrupt bit |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are those where several events meet in one cycle. Examples are a read that drains the last character while a new one arrives, a break while the queue is full, and a flush that coincides with a read while the break flag is set.

A directed sequence first walks through each boundary in turn: fill, overrun, drain, stale read, break insertion, and enable/disable collisions. After that, a long pseudo-random sweep drives all inputs at once, with per-input densities chosen so that collisions happen often. It compares every output in every cycle against an arithmetic queue model kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Wrapped addition of two slot indices below a modulus.
  function automatic int wrap_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

  typedef struct packed {
    logic push_ok;
    logic pop_ok;
    logic drain;
  } rxq_evt_t;

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int DEPTH = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output rxq_pkg::rxq_evt_t evt,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] pending
);
  import rxq_pkg::*;

  logic [IDX_W-1:0] rd_idx_n;
  logic [CNT_W-1:0] pending_n;
  logic [CNT_W-1:0] after_cnt;

  always_comb begin
    evt.push_ok = push_req && (pending < CNT_W'(DEPTH));
    evt.pop_ok  = pop_req && (pending != '0);
    evt.drain   = evt.pop_ok && !evt.push_ok && (pending == CNT_W'(1));
    wr_idx      = IDX_W'(wrap_add(int'(rd_idx), int'(pending), DEPTH));
  end

  always_comb begin
    after_cnt = pending + CNT_W'(evt.push_ok) - CNT_W'(evt.pop_ok);
    rd_idx_n  = rd_idx;
    pending_n = pending;
    if (flush) begin
      pending_n = '0;
    end else begin
      pending_n = after_cnt;
      if (evt.pop_ok && (after_cnt != '0))
        rd_idx_n = IDX_W'(wrap_add(int'(rd_idx), 1, DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      pending <= '0;
    end else begin
      rd_idx  <= rd_idx_n;
      pending <= pending_n;
    end
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (slot_we)
        slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
  end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic              clk,
  input  logic              rst_n,
  input  rxq_pkg::rxq_evt_t evt,
  input  logic              on_cmd,
  input  logic              off_cmd,
  input  logic              flush,
  input  logic              brk_evt,
  input  logic              ovf_evt,
  input  logic              brk_ack,
  input  logic              err_clr,
  output logic              rx_on,
  output logic              rdy,
  output logic              brk_sts,
  output logic              brk_int,
  output logic              ovr
);

  logic rx_on_n, rdy_n, brk_sts_n, brk_int_n, ovr_n;
  logic brk_consume;

  always_comb begin
    brk_consume = evt.pop_ok && brk_sts;

    rx_on_n = rx_on;
    if (flush || off_cmd) rx_on_n = 1'b0;
    else if (on_cmd)      rx_on_n = 1'b1;

    rdy_n = rdy;
    if (flush)             rdy_n = 1'b0;
    else if (evt.push_ok)  rdy_n = 1'b1;
    else if (evt.drain)    rdy_n = 1'b0;

    brk_sts_n = brk_sts;
    if (brk_consume) brk_sts_n = 1'b0;
    if (err_clr)     brk_sts_n = 1'b0;
    if (brk_evt)     brk_sts_n = 1'b1;

    brk_int_n = brk_int;
    if (brk_ack)     brk_int_n = 1'b0;
    if (brk_consume) brk_int_n = 1'b1;

    ovr_n = ovr;
    if (err_clr) ovr_n = 1'b0;
    if (ovf_evt) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on   <= 1'b0;
      rdy     <= 1'b0;
      brk_sts <= 1'b0;
      brk_int <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      rx_on   <= rx_on_n;
      rdy     <= rdy_n;
      brk_sts <= brk_sts_n;
      brk_int <= brk_int_n;
      ovr     <= ovr_n;
    end
  end

endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [DATA_W-1:0]          rx_char,
  input  logic                       rx_break,
  output logic [$clog2(DEPTH+1)-1:0] rx_free,
  input  logic                       host_rd,
  output logic [DATA_W-1:0]          host_data,
  input  logic                       cmd_rx_on,
  input  logic                       cmd_rx_off,
  input  logic                       cmd_rx_flush,
  input  logic                       cmd_brk_ack,
  input  logic                       cmd_err_clr,
  output logic                       rx_ready,
  output logic                       brk_flag,
  output logic                       brk_irq,
  output logic                       overrun,
  output logic                       irq
);
  import rxq_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              rx_on;
  logic              push_req;
  logic              ovf_evt;
  logic [DATA_W-1:0] push_data;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [CNT_W-1:0]  pending;
  rxq_evt_t          evt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    push_req  = rx_on && !cmd_rx_flush && (rx_valid || rx_break);
    push_data = rx_break ? '0 : rx_char;
    ovf_evt   = push_req && (pending == CNT_W'(DEPTH));
    rx_free   = rx_on ? (CNT_W'(DEPTH) - pending) : '0;
    irq       = rx_ready || brk_irq;
  end

  rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .push_req (push_req),
    .pop_req  (host_rd),
    .flush    (cmd_rx_flush),
    .evt      (evt),
    .rd_idx   (rd_idx),
    .wr_idx   (wr_idx),
    .pending  (pending)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (evt.push_ok),
    .wr_idx  (wr_idx),
    .wr_data (push_data),
    .rd_idx  (rd_idx),
    .rd_data (host_data)
  );

  rxq_flags u_flags (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .evt     (evt),
    .on_cmd  (cmd_rx_on),
    .off_cmd (cmd_rx_off),
    .flush   (cmd_rx_flush),
    .brk_evt (rx_break),
    .ovf_evt (ovf_evt),
    .brk_ack (cmd_brk_ack),
    .err_clr (cmd_err_clr),
    .rx_on   (rx_on),
    .rdy     (rx_ready),
    .brk_sts (brk_flag),
    .brk_int (brk_irq),
    .ovr     (overrun)
  );

endmodule

// File: rtl/rx_hold_queue_chk.sv
module rx_hold_queue_chk #(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             host_rd,
  input logic             cmd_rx_off,
  input logic             cmd_rx_flush,
  input logic [CNT_W-1:0] rx_free,
  input logic             rx_ready,
  input logic             brk_flag,
  input logic             brk_irq,
  input logic             overrun
);

  // R2
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_free <= CNT_W'(DEPTH));

  // R2
  off_no_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_off |=> (rx_free == '0));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_flush |=> (!rx_ready && rx_free == '0));

  // R3
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_valid || rx_break));

  // R4
  empty_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_free == CNT_W'(DEPTH)) |-> !rx_ready);

  // R7
  brk_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_irq) |-> $past(host_rd && brk_flag));

  // R9
  overrun_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid || rx_break));

endmodule

bind rx_hold_queue rx_hold_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .host_rd      (host_rd),
  .cmd_rx_off   (cmd_rx_off),
  .cmd_rx_flush (cmd_rx_flush),
  .rx_free      (rx_free),
  .rx_ready     (rx_ready),
  .brk_flag     (brk_flag),
  .brk_irq      (brk_irq),
  .overrun      (overrun)
);

// File: tb/test_rx_hold_queue.sv
module test_rx_hold_queue;
  localparam int DW    = 8;
  localparam int DEPTH = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, rx_break, host_rd;
  logic [DW-1:0] rx_char;
  logic          cmd_rx_on, cmd_rx_off, cmd_rx_flush, cmd_brk_ack, cmd_err_clr;
  logic [CW-1:0] rx_free;
  logic [DW-1:0] host_data;
  logic          rx_ready, brk_flag, brk_irq, overrun, irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [DW-1:0] m_q [DEPTH];
  int            m_idx, m_pend;
  bit            m_on, m_bs, m_bi, m_ov;

  always #5 clk = ~clk;

  rx_hold_queue #(.DATA_W(DW), .DEPTH(DEPTH)) i_rx_hold_queue (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_break(rx_break), .rx_free(rx_free), .host_rd(host_rd),
    .host_data(host_data), .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off),
    .cmd_rx_flush(cmd_rx_flush), .cmd_brk_ack(cmd_brk_ack),
    .cmd_err_clr(cmd_err_clr), .rx_ready(rx_ready), .brk_flag(brk_flag),
    .brk_irq(brk_irq), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 head data", int'(host_data), int'(m_q[m_idx]));
    chk("R2 free slots", int'(rx_free), m_on ? DEPTH - m_pend : 0);
    chk("R3 ready", int'(rx_ready), int'(m_pend != 0));
    chk("R6 break flag", int'(brk_flag), int'(m_bs));
    chk("R7 break irq", int'(brk_irq), int'(m_bi));
    chk("R9 overrun", int'(overrun), int'(m_ov));
    chk("R11 irq", int'(irq), int'((m_pend != 0) || m_bi));
  endtask

  task automatic model_step(input bit p, input logic [DW-1:0] d, input bit b,
                            input bit r, input bit en, input bit dis,
                            input bit fl, input bit ba, input bit ec);
    bit pushq, acc, pop, cons;
    int np;
    pushq = !fl && m_on && (p || b);
    acc   = pushq && (m_pend < DEPTH);
    pop   = r && (m_pend > 0);
    cons  = pop && m_bs;
    if (pushq && m_pend == DEPTH) m_ov = 1'b1;
    else if (ec) m_ov = 1'b0;
    if (acc) m_q[(m_idx + m_pend) % DEPTH] = b ? '0 : d;
    if (!fl) begin
      np = m_pend + int'(acc) - int'(pop);
      if (pop && np != 0) m_idx = (m_idx + 1) % DEPTH;
      m_pend = np;
    end else begin
      m_pend = 0;
    end
    if (fl || dis) m_on = 1'b0;
    else if (en)   m_on = 1'b1;
    if (cons) m_bs = 1'b0;
    if (ec)   m_bs = 1'b0;
    if (b)    m_bs = 1'b1;
    if (ba)   m_bi = 1'b0;
    if (cons) m_bi = 1'b1;
  endtask

  // called at a falling edge; drives, clocks, checks at next falling edge
  task automatic apply(input bit p, input logic [DW-1:0] d, input bit b,
                       input bit r, input bit en, input bit dis,
                       input bit fl, input bit ba, input bit ec);
    rx_valid = p; rx_char = d; rx_break = b; host_rd = r;
    cmd_rx_on = en; cmd_rx_off = dis; cmd_rx_flush = fl;
    cmd_brk_ack = ba; cmd_err_clr = ec;
    @(posedge clk);
    model_step(p, d, b, r, en, dis, fl, ba, ec);
    @(negedge clk);
    rx_valid = 0; rx_char = '0; rx_break = 0; host_rd = 0;
    cmd_rx_on = 0; cmd_rx_off = 0; cmd_rx_flush = 0;
    cmd_brk_ack = 0; cmd_err_clr = 0;
    compare_all();
  endtask

  task automatic push(input logic [DW-1:0] d);
    apply(1, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd();
    apply(0, '0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 0;
    rx_valid = 0; rx_char = '0; rx_break = 0; host_rd = 0;
    cmd_rx_on = 0; cmd_rx_off = 0; cmd_rx_flush = 0;
    cmd_brk_ack = 0; cmd_err_clr = 0;
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    m_idx = 0; m_pend = 0; m_on = 0; m_bs = 0; m_bi = 0; m_ov = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready", int'(rx_ready), 0);
    chk("R12 free", int'(rx_free), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 data", int'(host_data), 0);
    chk("R12 flags", int'({brk_flag, brk_irq, overrun}), 0);
    rst_n = 1;
    repeat (3) apply(0, '0, 0, 0, 0, 0, 0, 0, 0);

    // R2 push while off ignored
    push(8'hAA);
    chk("R2 off push ignored", int'(rx_ready), 0);
    apply(0, '0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 enable", int'(rx_free), DEPTH);
    push(8'h11); push(8'h22); push(8'h33);
    chk("R1 full", int'(rx_free), 0);
    chk("R1 head first", int'(host_data), 'h11);
    push(8'h44);
    chk("R9 overrun set", int'(overrun), 1);
    rd();
    chk("R1 order 2", int'(host_data), 'h22);
    rd();
    chk("R1 order 3", int'(host_data), 'h33);
    rd();
    chk("R4 last read clears ready", int'(rx_ready), 0);
    rd();
    chk("R5 stale read data", int'(host_data), 'h33);
    chk("R5 stale read space", int'(rx_free), DEPTH);
    apply(0, '0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 err clear", int'(overrun), 0);
    apply(0, '0, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 break flag", int'(brk_flag), 1);
    chk("R6 zero char", int'(host_data), 0);
    chk("R6 one slot", int'(rx_free), DEPTH - 1);
    rd();
    chk("R7 flag cleared", int'(brk_flag), 0);
    chk("R7 irq raised", int'(brk_irq), 1);
    apply(0, '0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 ack", int'(brk_irq), 0);
    apply(1, 8'h55, 0, 0, 1, 1, 0, 0, 0);
    chk("R10 off wins", int'(rx_free), 0);
    apply(0, '0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 push judged on old enable", int'(rx_free), DEPTH - 1);
    apply(1, 8'h66, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 flush ready", int'(rx_ready), 0);
    chk("R8 flush off", int'(rx_free), 0);
    apply(0, '0, 0, 0, 1, 0, 0, 0, 0);
    apply(1, 8'h77, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 break beats data", int'(host_data), 0);
    chk("R6 single char", int'(rx_free), DEPTH - 1);

    // pseudo-random sweep against the model
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      bit p, b, r, en, dis, fl, ba, ec;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      p   = lf[0];
      b   = (lf[4:1] == 4'd0);
      r   = (lf[7:5] < 3'd3);
      en  = (lf[10:8] == 3'd0) || (n % 37 == 0);
      dis = (lf[14:10] == 5'd3);
      fl  = (lf[15:11] == 5'd7) && lf[1];
      ba  = (lf[9:7] == 3'd5);
      ec  = (lf[12:9] == 4'd6);
      apply(p, {lf[3:0], lf[11:8]}, b, r, en, dis, fl, ba, ec);
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule